// File: doc/BRIEF.md
# Round-Robin 66-Bit Block Lane Dealer with Physical-Lane Bit Interleaver

This block takes one stream of 66-bit blocks from a de-mapper and hands them out to twenty PCS lanes. The first block goes to lane 0, the next to lane 1, and so on up to lane 19, after which the order starts again at lane 0. Each PCS lane keeps one 66-bit holding buffer. When all twenty buffers hold a block, the whole set (a "round") moves to a serializer, which frees the buffers for the next round.

The egress side has `NUM_PHY` physical lanes, and `NUM_PHY` must divide 20. Physical lane p carries PCS lanes p, p+NUM_PHY, p+2·NUM_PHY and so on. It sends one bit per cycle, taking the next lane of its group on each cycle, and sends bit 0 of each block first. A round therefore lasts 66·(20/NUM_PHY) cycles.

Incoming blocks are used only while the block-lock input is high. The dealer has two states, HUNT and RUN. It moves HUNT→RUN when lock is seen high and RUN→HUNT when lock drops. The serializer has two states, IDLE and SHIFT. It moves IDLE→SHIFT when it takes a complete round. At the end of a round it moves SHIFT→SHIFT if the next round is already complete, and SHIFT→IDLE if it is not.

Top module: `lane_distributor`

## Requirements
- R1: Blocks presented while `blk_lock` is low are discarded. Blocks presented in the first cycle that `blk_lock` is high are also discarded, because the dealer is still in HUNT. Acceptance begins in the following cycle.
- R2: Within a round, the n-th accepted block (n = 0..19) is stored for PCS lane n. The first block after reset, or after lock is regained, lands on lane 0.
- R3: When `blk_lock` goes low, the dealer enters HUNT, resets its pointer to lane 0 and discards every block not yet handed to the serializer. None of those blocks ever appears on the outputs.
- R4: When the 20th block of a round is accepted and the serializer is idle, `phy_valid` rises two cycles after the cycle that presented that block. The holding buffers are free again at that point. A lane's buffer is never written while it is still full.
- R5: In cycle j (j = 0 .. 66·L−1, where L = 20/NUM_PHY) of a round, `phy_bit[p]` equals bit ⌊j/L⌋ of the block held by PCS lane p + (j mod L)·NUM_PHY.
- R6: `phy_valid` stays high for exactly 66·L cycles per round. If the next round is already complete when a round ends, the next round follows with no idle cycle between them.
- R7: After reset, `phy_valid` and `phy_bit` are 0, and the lane pointer is at lane 0.
- R8: `phy_bit` is all zeros whenever `phy_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | A block is present on `blk_data` |
| blk_data | input | BLK_W (66) | 66-bit block, sync header included |
| blk_lock | input | 1 | Incoming stream is in 66B block lock |
| phy_valid | output | 1 | A round is being sent on the physical lanes |
| phy_bit | output | NUM_PHY | One bit per physical lane per cycle |

## Verification
The bench sends a round of twenty blocks back to back. It checks the cycle in which `phy_valid` rises, then rebuilds the block order by undoing the interleave and compares it with the input. A design that mixed up the lane group or the bit order would return the blocks scrambled.

Stale blocks are the main target. The bench presents blocks before lock, in the very cycle lock rises, and as a partial round cut short by lock loss. A design that kept any of these would shift every later block to the wrong lane.

Two rounds are then sent so that the second is complete while the first is still being sent. A serializer that went back to IDLE between them would open a gap in `phy_valid`. One that reloaded too early would cut the first round short.

// File: rtl/lanedist_pkg.sv
package lanedist_pkg;

    typedef enum logic {DS_HUNT, DS_RUN} dist_state_t;
    typedef enum logic {SS_IDLE, SS_SHIFT} ser_state_t;

    // Counter width for a range of n values, never below one bit.
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lane_dealer.sv
module lane_dealer
    import lanedist_pkg::*;
#(
    parameter int NUM_PCS = 20,
    parameter int BLK_W   = 66
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     blk_valid,
    input  logic [BLK_W-1:0]         blk_data,
    input  logic                     blk_lock,
    input  logic                     take,
    output logic                     round_ready,
    output logic [NUM_PCS*BLK_W-1:0] hold_flat
);

    localparam int PTR_W = cnt_w(NUM_PCS);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_PCS - 1);

    dist_state_t       state, state_nx;
    logic [PTR_W-1:0]  ptr;
    logic [NUM_PCS-1:0] full;
    logic [BLK_W-1:0]  hold [NUM_PCS];
    logic              accept;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DS_HUNT;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            DS_HUNT: if (blk_lock)  state_nx = DS_RUN;
            DS_RUN:  if (!blk_lock) state_nx = DS_HUNT;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        accept = 1'b0;
        unique case (state)
            DS_HUNT: accept = 1'b0;
            DS_RUN:  accept = blk_lock && blk_valid;
        endcase
    end

    // Round-robin pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ptr <= '0;
        else if (!blk_lock) ptr <= '0;
        else if (accept)    ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    end

    // Holding buffers with occupancy flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= '0;
            for (int i = 0; i < NUM_PCS; i++) hold[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_PCS; i++) begin
                if (!blk_lock) begin
                    full[i] <= 1'b0;
                end else if (accept && ptr == PTR_W'(i)) begin
                    full[i] <= 1'b1;
                    hold[i] <= blk_data;
                end else if (take) begin
                    full[i] <= 1'b0;
                end
            end
        end
    end

    assign round_ready = &full;

    for (genvar g = 0; g < NUM_PCS; g++) begin : g_flat
        assign hold_flat[g*BLK_W +: BLK_W] = hold[g];
    end

    a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_LAST);

    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ptr == (($past(ptr) == PTR_LAST) ? '0 : $past(ptr) + 1'b1)));

    a_r3_flush_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_lock |=> (full == '0 && ptr == '0));

    a_r1_hunt_stores_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DS_HUNT) |=> ($countones(full) <= $countones($past(full))));

    a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !full[ptr]);

endmodule

// File: rtl/lane_weaver.sv
module lane_weaver
    import lanedist_pkg::*;
#(
    parameter int NUM_PCS = 20,
    parameter int NUM_PHY = 4,
    parameter int BLK_W   = 66
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     round_ready,
    input  logic [NUM_PCS*BLK_W-1:0] hold_flat,
    output logic                     take,
    output logic                     phy_valid,
    output logic [NUM_PHY-1:0]       phy_bit
);

    localparam int LPP   = NUM_PCS / NUM_PHY;
    localparam int SEL_W = cnt_w(LPP);
    localparam int BIT_W = cnt_w(BLK_W);
    localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(LPP - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BLK_W - 1);

    ser_state_t        state, state_nx;
    logic [SEL_W-1:0]  sel;
    logic [BIT_W-1:0]  bidx;
    logic [BLK_W-1:0]  sreg [NUM_PCS];
    logic              last;

    assign last = (state == SS_SHIFT) && (sel == SEL_LAST) && (bidx == BIT_LAST);
    assign take = round_ready && ((state == SS_IDLE) || last);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SS_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            SS_IDLE:  if (take) state_nx = SS_SHIFT;
            SS_SHIFT: if (last) state_nx = take ? SS_SHIFT : SS_IDLE;
        endcase
    end

    // Lane-select and bit-index counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel  <= '0;
            bidx <= '0;
        end else if (take) begin
            sel  <= '0;
            bidx <= '0;
        end else if (state == SS_SHIFT) begin
            if (sel == SEL_LAST) begin
                sel  <= '0;
                bidx <= bidx + 1'b1;
            end else begin
                sel <= sel + 1'b1;
            end
        end
    end

    // Per-lane shift registers, each shifting on its own turn
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PCS; i++) sreg[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_PCS; i++) begin
                if (take)
                    sreg[i] <= hold_flat[i*BLK_W +: BLK_W];
                else if (state == SS_SHIFT && sel == SEL_W'(i / NUM_PHY))
                    sreg[i] <= sreg[i] >> 1;
            end
        end
    end

    // Outputs of the state machine
    always_comb begin
        phy_valid = 1'b0;
        phy_bit   = '0;
        unique case (state)
            SS_IDLE: phy_valid = 1'b0;
            SS_SHIFT: begin
                phy_valid = 1'b1;
                for (int p = 0; p < NUM_PHY; p++)
                    for (int k = 0; k < LPP; k++)
                        if (sel == SEL_W'(k)) phy_bit[p] = sreg[p + k*NUM_PHY][0];
            end
        endcase
    end

    a_r6_counters_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SS_SHIFT) |-> (bidx <= BIT_LAST && sel <= SEL_LAST));

    a_r6_end_after_full_round: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_valid) |-> $past(last));

    a_r4_take_starts_round: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (phy_valid && sel == '0 && bidx == '0));

endmodule

// File: rtl/lane_distributor.sv
module lane_distributor #(
    parameter int NUM_PCS = 20,
    parameter int NUM_PHY = 4,
    parameter int BLK_W   = 66
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               blk_valid,
    input  logic [BLK_W-1:0]   blk_data,
    input  logic               blk_lock,
    output logic               phy_valid,
    output logic [NUM_PHY-1:0] phy_bit
);

    logic                     take;
    logic                     round_ready;
    logic [NUM_PCS*BLK_W-1:0] hold_flat;

    lane_dealer #(
        .NUM_PCS (NUM_PCS),
        .BLK_W   (BLK_W)
    ) u_dealer (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_valid   (blk_valid),
        .blk_data    (blk_data),
        .blk_lock    (blk_lock),
        .take        (take),
        .round_ready (round_ready),
        .hold_flat   (hold_flat)
    );

    lane_weaver #(
        .NUM_PCS (NUM_PCS),
        .NUM_PHY (NUM_PHY),
        .BLK_W   (BLK_W)
    ) u_weaver (
        .clk         (clk),
        .rst_n       (rst_n),
        .round_ready (round_ready),
        .hold_flat   (hold_flat),
        .take        (take),
        .phy_valid   (phy_valid),
        .phy_bit     (phy_bit)
    );

    a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_valid |-> (phy_bit == '0));

endmodule

// File: tb/lane_distributor_test.sv
`timescale 1ns/1ps
module lane_distributor_test;

    localparam int NPCS = 20;
    localparam int NPHY = 4;
    localparam int BW   = 66;
    localparam int L    = NPCS / NPHY;
    localparam int RLEN = BW * L;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            blk_valid = 1'b0;
    logic [BW-1:0]   blk_data = '0;
    logic            blk_lock = 1'b0;
    logic            phy_valid;
    logic [NPHY-1:0] phy_bit;

    int checks = 0;
    int fails  = 0;

    logic [BW-1:0]   exp_q [0:127];
    int              exp_n = 0;
    logic [NPHY-1:0] cap [0:8191];
    int              cap_n = 0;
    int              run_len = 0;
    int              last_run = 0;
    int              quiet_err = 0;

    always #10 clk = ~clk;

    lane_distributor #(.NUM_PCS(NPCS), .NUM_PHY(NPHY), .BLK_W(BW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_valid (blk_valid),
        .blk_data  (blk_data),
        .blk_lock  (blk_lock),
        .phy_valid (phy_valid),
        .phy_bit   (phy_bit)
    );

    // Output capture, away from the active edge
    always @(negedge clk) begin
        if (phy_valid) begin
            cap[cap_n] = phy_bit;
            cap_n = cap_n + 1;
            run_len = run_len + 1;
        end else begin
            if (phy_bit != '0) quiet_err = quiet_err + 1;
            if (run_len != 0) last_run = run_len;
            run_len = 0;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [BW-1:0] rnd66();
        logic [95:0] t;
        t = {$urandom(), $urandom(), $urandom()};
        return t[BW-1:0];
    endfunction

    task automatic put(input logic [BW-1:0] d);
        @(negedge clk);
        blk_valid = 1'b1;
        blk_data  = d;
        @(negedge clk);
        blk_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Queue twenty fresh expected blocks and send them back to back
    task automatic send_round(output int eb);
        eb = exp_n;
        for (int i = 0; i < NPCS; i++) begin
            exp_q[exp_n] = rnd66();
            exp_n++;
        end
        for (int i = 0; i < NPCS; i++) begin
            @(negedge clk);
            blk_valid = 1'b1;
            blk_data  = exp_q[eb + i];
        end
        @(negedge clk);
        blk_valid = 1'b0;
    endtask

    task automatic wait_cap(input int target);
        while (cap_n < target) @(negedge clk);
        idle(2);
    endtask

    // Undo the interleave and compare each lane's block with the input order
    task automatic check_round(input int cb, input int eb, input string req);
        for (int n = 0; n < NPCS; n++) begin
            logic [BW-1:0] blk;
            int p, k;
            p = n % NPHY;
            k = n / NPHY;
            for (int b = 0; b < BW; b++) blk[b] = cap[cb + b*L + k][p];
            chk(blk == exp_q[eb + n], req, blk, exp_q[eb + n]);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        chk(phy_valid == 1'b0, "R7 valid after reset", phy_valid, 0);
        chk(phy_bit == '0, "R7 bits after reset", phy_bit, 0);
        rst_n = 1'b1;
        idle(2);
        chk(phy_valid == 1'b0, "R7 valid after release", phy_valid, 0);
    endtask

    task automatic t_basic();
        int cb, eb;
        blk_lock = 1'b1;
        idle(3);
        cb = cap_n;
        send_round(eb);
        chk(phy_valid == 1'b0, "R4 valid one cycle after last block", phy_valid, 0);
        @(negedge clk);
        chk(phy_valid == 1'b1, "R4 valid two cycles after last block", phy_valid, 1);
        wait_cap(cb + RLEN);
        chk(last_run == RLEN, "R6 round length", last_run, RLEN);
        check_round(cb, eb, "R2 R5 R7 basic round order");
    endtask

    task automatic t_hunt();
        int cb, eb;
        blk_lock = 1'b0;
        idle(2);
        cb = cap_n;
        for (int i = 0; i < 5; i++) put(rnd66());
        @(negedge clk);
        blk_lock  = 1'b1;
        blk_valid = 1'b1;
        blk_data  = rnd66();
        @(negedge clk);
        blk_valid = 1'b0;
        chk(cap_n == cb, "R1 nothing sent from unlocked blocks", cap_n, cb);
        send_round(eb);
        wait_cap(cb + RLEN);
        chk(cap_n == cb + RLEN, "R1 exactly one round sent", cap_n, cb + RLEN);
        check_round(cb, eb, "R1 blocks before lock discarded");
    endtask

    task automatic t_lock_loss();
        int cb, eb;
        cb = cap_n;
        for (int i = 0; i < 7; i++) put(rnd66());
        @(negedge clk);
        blk_lock = 1'b0;
        idle(3);
        chk(cap_n == cb, "R3 partial round not sent", cap_n, cb);
        blk_lock = 1'b1;
        idle(2);
        send_round(eb);
        wait_cap(cb + RLEN);
        chk(cap_n == cb + RLEN, "R3 only new round sent", cap_n, cb + RLEN);
        check_round(cb, eb, "R3 restart at lane 0 after lock loss");
    endtask

    task automatic t_back_to_back();
        int cb, ea, ebb;
        cb = cap_n;
        send_round(ea);
        idle(3);
        send_round(ebb);
        wait_cap(cb + 2*RLEN);
        chk(last_run == 2*RLEN, "R6 no gap between rounds", last_run, 2*RLEN);
        check_round(cb, ea, "R6 first of two rounds");
        check_round(cb + RLEN, ebb, "R6 second of two rounds");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_hunt();
        t_lock_loss();
        t_back_to_back();
        idle(2);
        chk(quiet_err == 0, "R8 bits zero while not valid", quiet_err, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

endmodule